// File: doc/BRIEF.md
# Serial DAC Control Interface

This block is the digital front end of a 12-bit serially loaded converter. A host writes 16-bit frames over a three-wire port made of an active-low select, a serial clock and a data line. Each frame is decoded into a command. The command acts on two registers: a staging register and the register that drives the converter code. It can load the staging register, load both registers, or promote the staging value to the output. A subcommand space covers four further actions: entering power-down, setting a general-purpose output pin, choosing the timing of the daisy-chain output, or doing nothing.

All serial and control pins are brought into one system clock through synchronisers and then edge-detected. The system clock must run at least four times faster than the serial clock. Power-down is sticky. It is entered by a command or by a rising edge on a hardware pin, and only while the lockout enable pin is high. It is left by a data-carrying command or by a falling edge on the lockout pin. A clear pin forces the output code to zero or to midscale, as chosen by a static strap pin that also sets the value loaded at reset. The bit shifted out of the receive register is presented on a chain output so that several devices can share one data line in series.

Top module: `sdac_frontend`

## Requirements
- R1: A frame is exactly 16 serial-clock rising edges taken while select is low, most significant bit first. Bits 15:14 are the command, bits 13:2 are the 12-bit data and bits 1:0 are ignored. The command acts once, when select returns high.
- R2: Serial clock and data are ignored while select is high. A frame may be sent in two 8-bit bursts with the serial clock idle in between, provided select stays low throughout.
- R3: When select rises after any number of bits other than 16, no register changes.
- R4: Command 00 loads the staging register and leaves the output code unchanged. Command 01 loads both registers. Command 10 copies the staging register into the output code.
- R5: Command 11 decodes data bits 11:9 as a subcommand. Values 000 and 001 do nothing. Values 010 and 011 enter power-down, but only when the lockout pin is high.
- R6: A rising edge on the hardware shutdown pin while the lockout pin is high enters power-down. A falling edge on that pin does not leave power-down. While the lockout pin is low, neither the pin nor the subcommand enters power-down.
- R7: Power-down is left by command 01, by command 10, or by a falling edge on the lockout pin. During power-down, frames are still received and the staging register can be loaded, and the output code keeps its value.
- R8: While clear is high, the output code is 0x000 when the strap pin is low or 0x800 when it is high, and the user output is driven low. Clear overrides any command decoded in the same cycle.
- R9: Subcommand 100 drives the user output low and subcommand 101 drives it high.
- R10: Subcommand 110 selects chain mode 1 and subcommand 111 selects chain mode 0. In mode 0 the chain output takes the receive register's top bit at each serial-clock falling edge. In mode 1 it takes the bit shifted out at each rising edge, which is half a serial clock later. In both modes it updates only while select is low.
- R11: After reset, both registers hold 0x000 when the strap pin is low or 0x800 when it is high. Power-down is off, the user output is low, mode 0 is selected and the chain output is low.

Frames, the lockout edge and the shutdown edge act within four system clocks of the pin edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| pdl | input | 1 | Lockout enable; high permits power-down, and a falling edge leaves it |
| shdn | input | 1 | Hardware shutdown request; acts on its rising edge |
| clr | input | 1 | Clear request, active high |
| rsel | input | 1 | Static strap: low selects zero, high selects midscale |
| dac_code | output | 12 | Output code register |
| pwr_down | output | 1 | Power-down flag; the converter output is high impedance |
| user_out | output | 1 | General-purpose output level |
| chain_out | output | 1 | Daisy-chain serial output |

## Verification
A miscounted bit position or a wrong bit count shows at the output code within four system clocks of select rising, because the wrong data is loaded or a valid frame is dropped. A power-down flag that sticks or clears too early shows at once on the flag, after the pin edge or the command that should have moved it. A wrong chain timing shows on the chain output half a serial clock early or late, in the middle of the frame that follows. The reference model compares every output on every system clock once the inputs have been quiet long enough for the synchronisers to settle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int CMD_W = 2;
  localparam int SEL_W = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_LOAD_STAGE = 2'b00,
    CMD_LOAD_BOTH  = 2'b01,
    CMD_PROMOTE    = 2'b10,
    CMD_EXTENDED   = 2'b11
  } cmd_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int FRAME_W = 16,
  parameter int SUB_W = 2,
  localparam int KEEP_W = FRAME_W - SUB_W,
  localparam int CNT_W = $clog2(FRAME_W) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_low,
  input  logic              cs_rise,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              sdi_s,
  input  logic              mode1,
  output logic              frame_ok,
  output logic [KEEP_W-1:0] frame_word,
  output logic              chain_out
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr         <= '0;
      cnt        <= '0;
      frame_ok   <= 1'b0;
      frame_word <= '0;
      chain_out  <= 1'b0;
    end else begin
      frame_ok <= 1'b0;
      if (cs_rise) begin
        frame_ok   <= (cnt == CNT_W'(FRAME_W));
        frame_word <= sr[FRAME_W-1:SUB_W];
        cnt        <= '0;
      end else if (cs_low && sclk_rise) begin
        sr <= {sr[FRAME_W-2:0], sdi_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        if (mode1) chain_out <= sr[FRAME_W-1];
      end else if (cs_low && sclk_fall && !mode1) begin
        chain_out <= sr[FRAME_W-1];
      end
    end
  end
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int CODE_W = 12,
  localparam int KEEP_W = CMD_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_ok,
  input  logic [KEEP_W-1:0] frame_word,
  input  logic              pdl_s,
  input  logic              pdl_fall,
  input  logic              shdn_rise,
  input  logic              clr_s,
  input  logic              rsel,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              user_out,
  output logic              mode1
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  cmd_e              cmd;
  logic [CODE_W-1:0] data;
  logic [SEL_W-1:0]  sel;
  logic [CODE_W-1:0] stage_code;

  assign cmd  = cmd_e'(frame_word[KEEP_W-1 -: CMD_W]);
  assign data = frame_word[CODE_W-1:0];
  assign sel  = data[CODE_W-1 -: SEL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_code <= rsel ? MID : '0;
      dac_code   <= rsel ? MID : '0;
      pwr_down   <= 1'b0;
      user_out   <= 1'b0;
      mode1      <= 1'b0;
    end else begin
      if (pdl_fall) pwr_down <= 1'b0;
      if (shdn_rise && pdl_s) pwr_down <= 1'b1;
      if (frame_ok) begin
        case (cmd)
          CMD_LOAD_STAGE: stage_code <= data;
          CMD_LOAD_BOTH: begin
            stage_code <= data;
            dac_code   <= data;
            pwr_down   <= 1'b0;
          end
          CMD_PROMOTE: begin
            dac_code <= stage_code;
            pwr_down <= 1'b0;
          end
          CMD_EXTENDED: begin
            if (!sel[2]) begin
              if (sel[1] && pdl_s) pwr_down <= 1'b1;
            end else begin
              case (sel[1:0])
                2'b00: user_out <= 1'b0;
                2'b01: user_out <= 1'b1;
                2'b10: mode1 <= 1'b1;
                default: mode1 <= 1'b0;
              endcase
            end
          end
          default: ;
        endcase
      end
      if (clr_s) begin
        dac_code <= rsel ? MID : '0;
        user_out <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sdac_frontend.sv
module sdac_frontend #(
  parameter int CODE_W = 12,
  parameter int SUB_W = 2,
  parameter int SYNC_STAGES = 2,
  localparam int FRAME_W = sdac_pkg::CMD_W + CODE_W + SUB_W,
  localparam int KEEP_W = FRAME_W - SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              pdl,
  input  logic              shdn,
  input  logic              clr,
  input  logic              rsel,
  output logic [CODE_W-1:0] dac_code,
  output logic              pwr_down,
  output logic              user_out,
  output logic              chain_out
);
  logic [3:0] edge_q, edge_qd;
  logic [1:0] lvl_q;
  logic cs_low, cs_rise, sclk_rise, sclk_fall;
  logic pdl_s, pdl_fall, shdn_rise, sdi_s, clr_s;
  logic frame_ok, mode1;
  logic [KEEP_W-1:0] frame_word;

  sdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0001)) u_sync_edge (
    .clk(clk), .rst(rst), .d({shdn, pdl, sclk, cs_n}), .q(edge_q)
  );

  sdac_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync_lvl (
    .clk(clk), .rst(rst), .d({clr, sdi}), .q(lvl_q)
  );

  always_ff @(posedge clk) begin
    if (rst) edge_qd <= 4'b0001;
    else     edge_qd <= edge_q;
  end

  assign cs_low    = !edge_q[0];
  assign cs_rise   = edge_q[0] && !edge_qd[0];
  assign sclk_rise = edge_q[1] && !edge_qd[1];
  assign sclk_fall = !edge_q[1] && edge_qd[1];
  assign pdl_s     = edge_q[2];
  assign pdl_fall  = !edge_q[2] && edge_qd[2];
  assign shdn_rise = edge_q[3] && !edge_qd[3];
  assign sdi_s     = lvl_q[0];
  assign clr_s     = lvl_q[1];

  sdac_shifter #(.FRAME_W(FRAME_W), .SUB_W(SUB_W)) u_shift (
    .clk(clk), .rst(rst), .cs_low(cs_low), .cs_rise(cs_rise),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .sdi_s(sdi_s),
    .mode1(mode1), .frame_ok(frame_ok), .frame_word(frame_word),
    .chain_out(chain_out)
  );

  sdac_regs #(.CODE_W(CODE_W)) u_regs (
    .clk(clk), .rst(rst), .frame_ok(frame_ok), .frame_word(frame_word),
    .pdl_s(pdl_s), .pdl_fall(pdl_fall), .shdn_rise(shdn_rise),
    .clr_s(clr_s), .rsel(rsel), .dac_code(dac_code), .pwr_down(pwr_down),
    .user_out(user_out), .mode1(mode1)
  );
endmodule

// File: rtl/sdac_frontend_chk.sv
module sdac_frontend_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              pdl_s,
  input logic              pdl_fall,
  input logic              shdn_rise,
  input logic              frame_ok,
  input logic              clr_s,
  input logic              sclk_rise,
  input logic              sclk_fall,
  input logic              rsel,
  input logic [CODE_W-1:0] dac_code,
  input logic              pwr_down,
  input logic              user_out,
  input logic              chain_out
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  a_r5_entry_needs_lockout: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> $past(pdl_s));

  a_r6_entry_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_down) |-> ($past(frame_ok) || $past(shdn_rise)));

  a_r7_exit_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(pwr_down) |-> ($past(frame_ok) || $past(pdl_fall)));

  a_r4_code_change_cause: assert property (@(posedge clk) disable iff (rst)
    !$stable(dac_code) |-> ($past(frame_ok) || $past(clr_s)));

  a_r8_clear_value: assert property (@(posedge clk) disable iff (rst)
    $past(clr_s) |-> (dac_code == (rsel ? MID : '0) && !user_out));

  a_r9_user_change_cause: assert property (@(posedge clk) disable iff (rst)
    !$stable(user_out) |-> ($past(frame_ok) || $past(clr_s)));

  a_r10_chain_on_edges: assert property (@(posedge clk) disable iff (rst)
    !$stable(chain_out) |-> ($past(sclk_rise) || $past(sclk_fall)));
endmodule

bind sdac_frontend sdac_frontend_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .pdl_s(pdl_s), .pdl_fall(pdl_fall),
  .shdn_rise(shdn_rise), .frame_ok(frame_ok), .clr_s(clr_s),
  .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .rsel(rsel),
  .dac_code(dac_code), .pwr_down(pwr_down), .user_out(user_out),
  .chain_out(chain_out)
);

// File: tb/sdac_frontend_test.sv
module sdac_frontend_test;
  localparam int PERIOD = 10;
  localparam int HALF_SCLK = 8;
  localparam int SETTLE = 6;

  logic clk = 0, rst = 1;
  logic cs_n = 1, sclk = 0, sdi = 0, pdl = 1, shdn = 0, clr = 0, rsel = 0;
  logic [11:0] dac_code;
  logic pwr_down, user_out, chain_out;

  sdac_frontend uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .pdl(pdl),
    .shdn(shdn), .clr(clr), .rsel(rsel), .dac_code(dac_code),
    .pwr_down(pwr_down), .user_out(user_out), .chain_out(chain_out)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_req = "R11";
  time last_chg = 0;

  logic [11:0] m_stage = 0, m_dac = 0;
  logic m_sd = 0, m_user = 0, m_mode1 = 0, m_chain = 0, m_cs_low = 0;
  logic [15:0] m_sr = 0;
  int m_cnt = 0;

  task automatic mark(); last_chg = $time; endtask
  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check1(input string what, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !finished && ($time - last_chg) >= SETTLE*PERIOD) begin
      check1("dac_code", dac_code, m_dac);
      check1("pwr_down", {11'b0, pwr_down}, {11'b0, m_sd});
      check1("user_out", {11'b0, user_out}, {11'b0, m_user});
      check1("chain_out", {11'b0, chain_out}, {11'b0, m_chain});
    end
  end

  task automatic model_reset();
    m_stage = rsel ? 12'h800 : 12'h000;
    m_dac = m_stage;
    m_sd = 0; m_user = 0; m_mode1 = 0; m_chain = 0; m_sr = 0; m_cnt = 0; m_cs_low = 0;
  endtask

  task automatic model_apply(input logic [15:0] w);
    logic [11:0] d;
    d = w[13:2];
    case (w[15:14])
      2'b00: m_stage = d;
      2'b01: begin m_stage = d; m_dac = d; m_sd = 0; end
      2'b10: begin m_dac = m_stage; m_sd = 0; end
      default: begin
        if (!d[11]) begin
          if (d[10] && pdl) m_sd = 1;
        end else begin
          case (d[10:9])
            2'b00: m_user = 0;
            2'b01: m_user = 1;
            2'b10: m_mode1 = 1;
            default: m_mode1 = 0;
          endcase
        end
      end
    endcase
  endtask

  task automatic cs_lo();
    cs_n = 0; m_cs_low = 1; mark(); wait_clk(HALF_SCLK);
  endtask

  task automatic cs_hi();
    cs_n = 1;
    if (m_cs_low && m_cnt == 16) model_apply(m_sr);
    m_cs_low = 0; m_cnt = 0; mark(); wait_clk(10);
  endtask

  task automatic clock_bit(input logic b);
    logic old;
    sdi = b; mark(); wait_clk(HALF_SCLK);
    sclk = 1;
    if (m_cs_low) begin
      old = m_sr[15];
      m_sr = {m_sr[14:0], b};
      m_cnt++;
      if (m_mode1) m_chain = old;
    end
    mark(); wait_clk(HALF_SCLK);
    sclk = 0;
    if (m_cs_low && !m_mode1) m_chain = m_sr[15];
    mark(); wait_clk(HALF_SCLK);
  endtask

  task automatic send(input logic [15:0] w, input int nbits);
    cs_lo();
    for (int i = 0; i < nbits; i++) clock_bit(i < 16 ? w[15-i] : 1'b0);
    cs_hi();
  endtask

  task automatic send_split(input logic [15:0] w);
    cs_lo();
    for (int i = 0; i < 8; i++) clock_bit(w[15-i]);
    wait_clk(30);
    for (int i = 8; i < 16; i++) clock_bit(w[15-i]);
    cs_hi();
  endtask

  function automatic logic [15:0] wd(input logic [1:0] c, input logic [11:0] d);
    return {c, d, 2'b00};
  endfunction

  function automatic logic [15:0] ext(input logic [2:0] s);
    return {2'b11, s, 9'h0AA, 2'b11};
  endfunction

  task automatic set_pin_wait();
    mark(); wait_clk(12);
  endtask

  initial begin
    model_reset();
    mark();
    wait_clk(5);
    rst = 0; mark();
    wait_clk(12);

    cur_req = "R1";
    send(wd(2'b01, 12'hA5C), 16);
    check1("R1 load", dac_code, 12'hA5C);

    cur_req = "R4";
    send(wd(2'b00, 12'h123), 16);
    check1("R4 stage only", dac_code, 12'hA5C);
    send(wd(2'b10, 12'hFFF), 16);
    check1("R4 promote", dac_code, 12'h123);

    cur_req = "R2";
    for (int i = 0; i < 5; i++) clock_bit(i[0]);
    send(wd(2'b10, 12'h000), 16);
    check1("R2 ignored while deselected", dac_code, 12'h123);
    send_split(wd(2'b01, 12'h7FF));
    check1("R2 split burst", dac_code, 12'h7FF);

    cur_req = "R3";
    send(wd(2'b01, 12'hFFF), 15);
    check1("R3 short frame", dac_code, 12'h7FF);
    send(wd(2'b01, 12'hFFF), 17);
    check1("R3 long frame", dac_code, 12'h7FF);

    cur_req = "R9";
    send(ext(3'b101), 16);
    check1("R9 user high", {11'b0, user_out}, 12'h001);
    send(ext(3'b100), 16);
    check1("R9 user low", {11'b0, user_out}, 12'h000);

    cur_req = "R5";
    send(ext(3'b000), 16);
    check1("R5 nop", {11'b0, pwr_down}, 12'h000);
    send(ext(3'b010), 16);
    check1("R5 soft shutdown", {11'b0, pwr_down}, 12'h001);

    cur_req = "R7";
    send(wd(2'b00, 12'h456), 16);
    check1("R7 load in shutdown", dac_code, 12'h7FF);
    send(wd(2'b10, 12'h000), 16);
    check1("R7 promote exits", {11'b0, pwr_down}, 12'h000);
    check1("R7 kept stage", dac_code, 12'h456);

    cur_req = "R6";
    shdn = 1; m_sd = 1; set_pin_wait();
    check1("R6 hw enter", {11'b0, pwr_down}, 12'h001);
    shdn = 0; set_pin_wait();
    check1("R6 release holds", {11'b0, pwr_down}, 12'h001);
    cur_req = "R7";
    pdl = 0; m_sd = 0; set_pin_wait();
    check1("R7 lockout fall exits", {11'b0, pwr_down}, 12'h000);
    cur_req = "R6";
    shdn = 1; set_pin_wait();
    shdn = 0; set_pin_wait();
    send(ext(3'b011), 16);
    check1("R6 lockout blocks", {11'b0, pwr_down}, 12'h000);
    pdl = 1; set_pin_wait();
    cur_req = "R7";
    send(ext(3'b011), 16);
    send(wd(2'b01, 12'h3C3), 16);
    check1("R7 load both exits", {11'b0, pwr_down}, 12'h000);
    check1("R7 new code", dac_code, 12'h3C3);

    cur_req = "R8";
    send(ext(3'b101), 16);
    clr = 1; m_dac = 12'h000; m_user = 0; set_pin_wait();
    check1("R8 clear zero", dac_code, 12'h000);
    check1("R8 clear user", {11'b0, user_out}, 12'h000);
    clr = 0; set_pin_wait();
    rsel = 1;
    clr = 1; m_dac = 12'h800; m_user = 0; set_pin_wait();
    check1("R8 clear mid", dac_code, 12'h800);
    clr = 0; set_pin_wait();

    cur_req = "R10";
    send(wd(2'b00, 12'hB6D), 16);
    send(ext(3'b110), 16);
    send(wd(2'b00, 12'h5A1), 16);
    send(wd(2'b00, 12'h0F0), 16);
    send(ext(3'b111), 16);
    send(wd(2'b00, 12'hC33), 16);
    check1("R10 chain after mode0", {11'b0, chain_out}, {11'b0, m_chain});

    cur_req = "R11";
    @(posedge clk); #1;
    rst = 1; mark();
    wait_clk(3);
    model_reset();
    rst = 0; mark();
    wait_clk(12);
    check1("R11 midscale reset", dac_code, 12'h800);
    send(wd(2'b10, 12'h000), 16);
    check1("R11 stage midscale", dac_code, 12'h800);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD*190000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog %s actual=hung expected=done", cur_req);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule